// File: doc/BRIEF.md
# Windowed Watchdog Timer with Postscaler

This block is a watchdog counter that advances on a prescaled base tick and expires after a power-of-two number of ticks. A 5-bit postscale code selects the exponent of that period. When the count reaches the period without being serviced, the block raises a one-cycle timeout pulse and starts counting again from zero. Clock source selection and whatever acts on the timeout lie outside the block.

In windowed mode, service is only legal in the final part of the period. A 2-bit code sets the size of that part as a percentage of the period. If a service strobe arrives before the window opens, the block raises a one-cycle early-service pulse and leaves the count alone. A service strobe inside the window restarts the count. Setting the window-disable input makes the watchdog a standard one, in which service is accepted at any time.

The watchdog runs when either the forced-enable input or the software on input is high. If the stop-during-programming input is set, the count is frozen while the programming-busy input is high. All outputs are registered.

Top module: `win_watchdog`

## Requirements
- R1: With effective exponent e, the period is P = 2^e base ticks. The base tick on which the count reaches P-1 and then advances again raises `timeout_pulse` for exactly the next cycle, and the count restarts at 0. The count only advances on cycles where `base_tick` is high.
- R2: `ps_code` values above MAX_EXP (default 20) are clamped to e = MAX_EXP, which gives the longest period of 2^MAX_EXP ticks.
- R3: In windowed mode (`win_off`=0), the window opens once the count reaches T = floor(P*k/8). The value of k comes from `win_code`: 00 gives k=2 (75% window), 01 gives k=4 (50%), 10 gives k=5 (37.5%) and 11 gives k=6 (25%). `win_open` is registered and is high in the cycle after an edge that leaves the count at T or above.
- R4: In windowed mode, a `kick` taken while the count is below T raises `early_pulse` for one cycle. The count is not changed.
- R5: A `kick` taken while the window is open, or at any time in standard mode, sets the count to 0. If a kick and the terminal tick fall on the same edge, the kick wins and no timeout is raised.
- R6: With `win_off`=1, `win_open` is high in every cycle after an enabled edge, and `early_pulse` never rises.
- R7: The watchdog is enabled when `force_on` OR `sw_on` is high. While it is disabled, the count is held at 0, `kick` is ignored, and all three outputs are low.
- R8: With `hold_in_prog`=1 and `prog_busy`=1, base ticks do not advance the count. With `hold_in_prog`=0, `prog_busy` has no effect.
- R9: Synchronous active-high `rst` clears the count and drives all outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_tick | input | 1 | Prescaled count enable, one pulse per base tick |
| ps_code | input | PS_W (5) | Postscale exponent code |
| win_code | input | 2 | Window size select |
| win_off | input | 1 | 1 selects standard mode, 0 selects windowed mode |
| force_on | input | 1 | Forces the watchdog on |
| sw_on | input | 1 | Software enable, used when force_on is 0 |
| hold_in_prog | input | 1 | Freeze the count while programming is busy |
| prog_busy | input | 1 | Programming in progress |
| kick | input | 1 | Service strobe |
| timeout_pulse | output | 1 | One-cycle pulse when the period expires |
| early_pulse | output | 1 | One-cycle pulse when service comes before the window |
| win_open | output | 1 | Service is currently accepted |

## Verification
The freeze property assumes that the configuration inputs stay unchanged across the cycles it relates. The bench only changes `ps_code`, `win_code` and `win_off` while the watchdog is disabled, or one cycle before re-enabling it. The checks on `timeout_pulse` and `early_pulse` assume that `kick` is a single-cycle strobe, driven half a cycle away from the clock edge. The bench drives every strobe and tick at the falling edge, so each one is seen at exactly one rising edge.

// File: rtl/win_wdt_pkg.sv
package win_wdt_pkg;

  // Window size selection; the code value orders the opening point.
  typedef enum logic [1:0] {
    WIN_75  = 2'b00,
    WIN_50  = 2'b01,
    WIN_375 = 2'b10,
    WIN_25  = 2'b11
  } win_sel_e;

endpackage

// File: rtl/win_wdt_period_dec.sv
module win_wdt_period_dec
  import win_wdt_pkg::*;
#(
  parameter int PS_W    = 5,
  parameter int MAX_EXP = 20,
  parameter int CNT_W   = MAX_EXP
) (
  input  logic [PS_W-1:0]  ps_code,
  input  win_sel_e         win_sel,
  output logic [CNT_W-1:0] term,
  output logic [CNT_W-1:0] thr
);

  localparam int CODE_MAX = (1 << PS_W) - 1;

  logic [PS_W-1:0]  exp_eff;
  logic [CNT_W-1:0] half;
  logic [CNT_W-1:0] quarter;
  logic [CNT_W-1:0] eighth;

  // Clamp only when the code range can exceed the longest period.
  generate
    if (CODE_MAX > MAX_EXP) begin : g_clamp
      assign exp_eff = (ps_code > PS_W'(MAX_EXP)) ? PS_W'(MAX_EXP) : ps_code;
    end else begin : g_pass
      assign exp_eff = ps_code;
    end
  endgenerate

  // half = P/2 (zero for P = 1).
  always_comb begin
    if (exp_eff == '0) half = '0;
    else               half = CNT_W'(1) << (exp_eff - PS_W'(1));
  end

  assign quarter = half >> 1;
  assign eighth  = half >> 2;

  // Last count value before the wrap: P - 1.
  assign term = (exp_eff == '0) ? '0 : ((half << 1) - CNT_W'(1));

  // Window opening point: floor(P * k / 8).
  always_comb begin
    unique case (win_sel)
      WIN_75:  thr = quarter;
      WIN_50:  thr = half;
      WIN_375: thr = half + eighth;
      WIN_25:  thr = half + quarter;
      default: thr = half;
    endcase
  end

endmodule

// File: rtl/win_wdt_counter.sv
module win_wdt_counter #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_en,
  input  logic             adv,
  input  logic             svc_clr,
  input  logic [CNT_W-1:0] term,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_nx,
  output logic             wrap
);

  logic at_end;

  // >= so that shrinking the period mid-count still wraps.
  assign at_end = (cnt_q >= term);
  assign wrap   = run_en & ~svc_clr & adv & at_end;

  always_comb begin
    if (!run_en)      cnt_nx = '0;
    else if (svc_clr) cnt_nx = '0;
    else if (adv)     cnt_nx = at_end ? '0 : cnt_q + CNT_W'(1);
    else              cnt_nx = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_nx;
  end

endmodule

// File: rtl/win_wdt_window.sv
module win_wdt_window #(
  parameter int CNT_W = 20
) (
  input  logic             win_off,
  input  logic             run_en,
  input  logic             kick,
  input  logic [CNT_W-1:0] cnt_q,
  input  logic [CNT_W-1:0] cnt_nx,
  input  logic [CNT_W-1:0] thr,
  output logic             svc_clr,
  output logic             early_hit,
  output logic             open_nx
);

  logic in_win_now;

  // Classification of a strobe uses the count it arrives against.
  assign in_win_now = win_off | (cnt_q >= thr);
  assign svc_clr    = run_en & kick & in_win_now;
  assign early_hit  = run_en & kick & ~in_win_now;

  // The flag follows the count that will hold after this edge.
  assign open_nx    = run_en & (win_off | (cnt_nx >= thr));

endmodule

// File: rtl/win_watchdog.sv
module win_watchdog
  import win_wdt_pkg::*;
#(
  parameter int PS_W    = 5,
  parameter int MAX_EXP = 20
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            base_tick,
  input  logic [PS_W-1:0] ps_code,
  input  logic [1:0]      win_code,
  input  logic            win_off,
  input  logic            force_on,
  input  logic            sw_on,
  input  logic            hold_in_prog,
  input  logic            prog_busy,
  input  logic            kick,
  output logic            timeout_pulse,
  output logic            early_pulse,
  output logic            win_open
);

  localparam int CNT_W = MAX_EXP;

  logic             run_en;
  logic             adv;
  logic [CNT_W-1:0] term;
  logic [CNT_W-1:0] thr;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nx;
  logic             wrap;
  logic             svc_clr;
  logic             early_hit;
  logic             open_nx;
  win_sel_e         win_sel;

  assign run_en  = force_on | sw_on;
  assign adv     = base_tick & ~(hold_in_prog & prog_busy);
  assign win_sel = win_sel_e'(win_code);

  win_wdt_period_dec #(
    .PS_W    (PS_W),
    .MAX_EXP (MAX_EXP),
    .CNT_W   (CNT_W)
  ) u_dec (
    .ps_code (ps_code),
    .win_sel (win_sel),
    .term    (term),
    .thr     (thr)
  );

  win_wdt_counter #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .run_en  (run_en),
    .adv     (adv),
    .svc_clr (svc_clr),
    .term    (term),
    .cnt_q   (cnt_q),
    .cnt_nx  (cnt_nx),
    .wrap    (wrap)
  );

  win_wdt_window #(
    .CNT_W (CNT_W)
  ) u_win (
    .win_off   (win_off),
    .run_en    (run_en),
    .kick      (kick),
    .cnt_q     (cnt_q),
    .cnt_nx    (cnt_nx),
    .thr       (thr),
    .svc_clr   (svc_clr),
    .early_hit (early_hit),
    .open_nx   (open_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      timeout_pulse <= 1'b0;
      early_pulse   <= 1'b0;
      win_open      <= 1'b0;
    end else begin
      timeout_pulse <= wrap;
      early_pulse   <= early_hit;
      win_open      <= open_nx;
    end
  end

endmodule

// File: rtl/win_watchdog_chk.sv
module win_watchdog_chk #(
  parameter int PS_W = 5
) (
  input logic            clk,
  input logic            rst,
  input logic            base_tick,
  input logic [PS_W-1:0] ps_code,
  input logic [1:0]      win_code,
  input logic            win_off,
  input logic            force_on,
  input logic            sw_on,
  input logic            hold_in_prog,
  input logic            prog_busy,
  input logic            kick,
  input logic            timeout_pulse,
  input logic            early_pulse,
  input logic            win_open
);

  // R7: a disabled cycle leaves every output low after the edge.
  p_off_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !(force_on | sw_on) |=> (!timeout_pulse && !early_pulse && !win_open));

  // R6: in standard mode the window is open whenever running.
  p_std_open_r6: assert property (@(posedge clk) disable iff (rst)
    ((force_on | sw_on) && win_off) |=> win_open);

  // R4: an early pulse needs a windowed-mode strobe one edge before.
  p_early_cause_r4: assert property (@(posedge clk) disable iff (rst)
    early_pulse |-> ($past(kick) && !$past(win_off)));

  // R5: a timeout needs a base tick with no strobe on the same edge.
  p_timeout_cause_r5: assert property (@(posedge clk) disable iff (rst)
    timeout_pulse |-> ($past(base_tick) && !$past(kick)));

  // R8: a frozen, unserviced edge keeps the flag and raises no timeout.
  p_freeze_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(force_on | sw_on) && (force_on | sw_on) &&
     hold_in_prog && prog_busy && !kick &&
     $stable(ps_code) && $stable(win_code) && $stable(win_off))
    |=> ($stable(win_open) && !timeout_pulse));

  // R4, R5: the two pulses never coincide.
  p_pulse_excl_r5: assert property (@(posedge clk) disable iff (rst)
    !(timeout_pulse && early_pulse));

endmodule

bind win_watchdog win_watchdog_chk #(.PS_W(PS_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .base_tick     (base_tick),
  .ps_code       (ps_code),
  .win_code      (win_code),
  .win_off       (win_off),
  .force_on      (force_on),
  .sw_on         (sw_on),
  .hold_in_prog  (hold_in_prog),
  .prog_busy     (prog_busy),
  .kick          (kick),
  .timeout_pulse (timeout_pulse),
  .early_pulse   (early_pulse),
  .win_open      (win_open)
);

// File: tb/win_watchdog_test.sv
`timescale 1ns/1ps
module win_watchdog_test;

  localparam int PS_W    = 5;
  localparam int MAX_EXP = 10;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            base_tick = 1'b0;
  logic [PS_W-1:0] ps_code = '0;
  logic [1:0]      win_code = '0;
  logic            win_off = 1'b0;
  logic            force_on = 1'b0;
  logic            sw_on = 1'b0;
  logic            hold_in_prog = 1'b0;
  logic            prog_busy = 1'b0;
  logic            kick = 1'b0;
  logic            timeout_pulse;
  logic            early_pulse;
  logic            win_open;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  win_watchdog #(.PS_W(PS_W), .MAX_EXP(MAX_EXP)) uut (
    .clk(clk), .rst(rst), .base_tick(base_tick), .ps_code(ps_code),
    .win_code(win_code), .win_off(win_off), .force_on(force_on),
    .sw_on(sw_on), .hold_in_prog(hold_in_prog), .prog_busy(prog_busy),
    .kick(kick), .timeout_pulse(timeout_pulse), .early_pulse(early_pulse),
    .win_open(win_open)
  );

  // Stimulus vectors: configuration, ticks before the strobe, and the
  // expected flag before the strobe, early pulse, and flag after it.
  typedef struct packed {
    logic [4:0] ps;
    logic [1:0] win;
    logic       off;
    logic [7:0] n;
    logic       open_b;
    logic       early;
    logic       open_a;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{5'd4, 2'b00, 1'b0, 8'd3,  1'b0, 1'b1, 1'b0},
    '{5'd4, 2'b00, 1'b0, 8'd4,  1'b1, 1'b0, 1'b0},
    '{5'd4, 2'b01, 1'b0, 8'd7,  1'b0, 1'b1, 1'b0},
    '{5'd4, 2'b01, 1'b0, 8'd8,  1'b1, 1'b0, 1'b0},
    '{5'd4, 2'b10, 1'b0, 8'd9,  1'b0, 1'b1, 1'b0},
    '{5'd4, 2'b10, 1'b0, 8'd10, 1'b1, 1'b0, 1'b0},
    '{5'd4, 2'b11, 1'b0, 8'd11, 1'b0, 1'b1, 1'b0},
    '{5'd4, 2'b11, 1'b0, 8'd12, 1'b1, 1'b0, 1'b0},
    '{5'd3, 2'b11, 1'b0, 8'd5,  1'b0, 1'b1, 1'b0},
    '{5'd4, 2'b11, 1'b1, 8'd2,  1'b1, 1'b0, 1'b1},
    '{5'd1, 2'b10, 1'b0, 8'd1,  1'b1, 1'b0, 1'b0},
    '{5'd0, 2'b00, 1'b0, 8'd0,  1'b1, 1'b0, 1'b1}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Disable for one edge (count to 0), then configure and enable.
  task automatic restart(input logic [4:0] ps, input logic [1:0] wc,
                         input logic off);
    sw_on = 1'b0; force_on = 1'b0; base_tick = 1'b0; kick = 1'b0;
    hold_in_prog = 1'b0; prog_busy = 1'b0;
    @(negedge clk);
    ps_code = ps; win_code = wc; win_off = off; sw_on = 1'b1;
  endtask

  task automatic ticks(input int n);
    base_tick = 1'b1;
    repeat (n) @(negedge clk);
    base_tick = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    n_err++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: reset state
    check("R9 timeout after reset", timeout_pulse, 0);
    check("R9 early after reset", early_pulse, 0);
    check("R9 open after reset", win_open, 0);

    // R3, R4, R5, R6: table walk
    for (int i = 0; i < NV; i++) begin
      restart(VECS[i].ps, VECS[i].win, VECS[i].off);
      if (VECS[i].n != 0) ticks(int'(VECS[i].n));
      @(negedge clk);
      check($sformatf("R3 open before strobe, vec %0d", i), win_open, VECS[i].open_b);
      kick = 1'b1;
      @(negedge clk);
      kick = 1'b0;
      check($sformatf("R4 early pulse, vec %0d", i), early_pulse, VECS[i].early);
      check($sformatf("R5 open after strobe, vec %0d", i), win_open, VECS[i].open_a);
    end

    // R1: period of 8 ticks, one-cycle pulse
    restart(5'd3, 2'b00, 1'b1);
    ticks(7);
    check("R1 no timeout before period", timeout_pulse, 0);
    ticks(1);
    check("R1 timeout at period", timeout_pulse, 1);
    @(negedge clk);
    check("R1 timeout lasts one cycle", timeout_pulse, 0);
    ticks(8);
    check("R1 count restarts after timeout", timeout_pulse, 1);

    // R5: strobe on the terminal tick wins
    restart(5'd2, 2'b00, 1'b1);
    ticks(3);
    kick = 1'b1;
    ticks(1);
    kick = 1'b0;
    check("R5 strobe beats terminal tick", timeout_pulse, 0);
    ticks(3);
    check("R5 count cleared by strobe", timeout_pulse, 0);
    ticks(1);
    check("R5 timeout after cleared period", timeout_pulse, 1);

    // R4: early strobe leaves the count unchanged (thr = 4)
    restart(5'd3, 2'b01, 1'b0);
    ticks(3);
    kick = 1'b1;
    @(negedge clk);
    kick = 1'b0;
    check("R4 early pulse", early_pulse, 1);
    ticks(1);
    check("R4 count kept after early strobe", win_open, 1);

    // R7: forced enable with software off
    restart(5'd2, 2'b00, 1'b1);
    sw_on = 1'b0; force_on = 1'b1;
    ticks(3);
    check("R7 forced enable runs (open)", win_open, 1);
    ticks(1);
    check("R7 forced enable timeout", timeout_pulse, 1);

    // R7: disabled ignores ticks and strobes
    restart(5'd2, 2'b00, 1'b0);
    sw_on = 1'b0;
    ticks(10);
    check("R7 disabled no timeout", timeout_pulse, 0);
    check("R7 disabled window closed", win_open, 0);
    kick = 1'b1;
    @(negedge clk);
    kick = 1'b0;
    check("R7 disabled strobe ignored", early_pulse, 0);

    // R8: freeze while programming (P = 4, thr = 2)
    restart(5'd2, 2'b01, 1'b0);
    hold_in_prog = 1'b1;
    ticks(1);
    prog_busy = 1'b1;
    ticks(5);
    check("R8 frozen window stays closed", win_open, 0);
    check("R8 frozen no timeout", timeout_pulse, 0);
    prog_busy = 1'b0;
    ticks(1);
    check("R8 resumes after busy", win_open, 1);
    hold_in_prog = 1'b0; prog_busy = 1'b1;
    ticks(1);
    check("R8 busy ignored without hold", timeout_pulse, 0);
    ticks(1);
    check("R8 busy ignored, timeout", timeout_pulse, 1);
    prog_busy = 1'b0;

    // R2: code 31 clamps to 2^10 (thr = 768)
    restart(5'd31, 2'b11, 1'b0);
    ticks(767);
    check("R2 clamped window closed", win_open, 0);
    ticks(1);
    check("R2 clamped window open", win_open, 1);
    ticks(255);
    check("R2 clamped no early timeout", timeout_pulse, 0);
    ticks(1);
    check("R2 clamped timeout", timeout_pulse, 1);

    // R9: reset mid-count restarts the period
    restart(5'd3, 2'b00, 1'b1);
    ticks(5);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R9 open low in reset cycle", win_open, 0);
    ticks(7);
    check("R9 count cleared by reset", timeout_pulse, 0);
    ticks(1);
    check("R9 timeout after full period", timeout_pulse, 1);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule